// File: doc/BRIEF.md
# Programmable Reset Distribution Controller

This block drives a bank of individual reset lines to on-chip peripherals and processor cores from a small register bus. Software asserts lines by writing ones into control words. Each control word covers 32 lines. Two status words show which lines are currently held, with a status bit of 0 meaning the line is asserted.

Most lines release themselves. Once a write starts a pulse on such a line, the line stays asserted for a fixed number of delay-clock-enable ticks and then drops with no further write. A small set of lines instead keeps whatever level the last write to its word gave it. A write of 0 to one of these lines releases it, so software must read status first and write back the state of the other held lines it wants to keep. Line 0 resets the main core and also raises a whole-system reset request.

The bus is single-cycle. A write takes effect at the clock edge that samples it. Read data is combinational from the current state while a read is presented.

Top module: `reset_dispatch`

## Requirements
- R1: After the block's own reset (rstN low), all self-releasing lines are released (lineRst bit 0), lines 12 and 56 are asserted (lineRst bit 1), and sysRstReq is 0.
- R2: Line n belongs to control and status word n/32, bit n%32. The control words sit at offsets 0x100 and 0x104, and the status words at 0x150 and 0x154.
- R3: A read of a status word returns 0 in each bit whose line is asserted and 1 in each bit whose line is released, reflecting the state before the current edge.
- R4: A write to a control word with 1 in a bit asserts that line starting from the clock edge that samples the write.
- R5: A self-releasing line started by a write stays asserted through exactly PULSE_TICKS (default 4) later edges sampled with tickEn high, then releases. Edges with tickEn low do not advance it, and a tick in the same cycle as the starting write is not counted.
- R6: Writing 1 to a self-releasing line that is still asserted restarts its full count of PULSE_TICKS ticks.
- R7: Writing 0 to a self-releasing line changes nothing, whether it is idle or counting.
- R8: Lines 12 and 56 take the value of their bit on every write to their control word (1 asserts or keeps them held, 0 releases them), and they keep that value regardless of ticks between writes.
- R9: sysRstReq is 1 exactly while line 0 (word 0, bit 0) is asserted.
- R10: Reads of the control words and of any unmapped offset return 0. Writes to unmapped offsets and to status offsets change no line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset of the block itself |
| tickEn | input | 1 | Delay-clock enable; one pulse-count step per edge where high |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when no read is presented |
| lineRst | output | 64 | Reset lines, 1 = asserted |
| sysRstReq | output | 1 | Whole-system reset request |

## Verification
The hardest situation to reach is a restart that lands while a pulse is partly counted, or a held line released as a side effect of a write meant for a different bit of the same word. Random stimulus biases writes toward few set bits and keeps tickEn sparse, so many writes arrive mid-count. Directed sequences place a rewrite two ticks into a pulse and clear word 0 while line 12 is held. A bench model of every line is compared against the full output vector on every cycle and against each status read.

// File: rtl/reset_dispatch_pkg.sv
package reset_dispatch_pkg;

  localparam int WORD_BITS = 32;
  localparam int WORD_IDX_W = 4;

  typedef struct packed {
    logic                  wrEn;
    logic [WORD_IDX_W-1:0] wrWord;
    logic                  rdStat;
    logic [WORD_IDX_W-1:0] rdWord;
  } busStrobe_t;

endpackage

// File: rtl/reset_dispatch_ctrl.sv
module reset_dispatch_ctrl
  import reset_dispatch_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_WORDS = 2,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] STAT_BASE = 12'h150
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (busValid && busWrite && busAddr == CTRL_BASE + ADDR_W'(4 * w)) begin
        strobe.wrEn   = 1'b1;
        strobe.wrWord = WORD_IDX_W'(w);
      end
      if (busValid && !busWrite && busAddr == STAT_BASE + ADDR_W'(4 * w)) begin
        strobe.rdStat = 1'b1;
        strobe.rdWord = WORD_IDX_W'(w);
      end
    end
  end

endmodule

// File: rtl/reset_dispatch_lines.sv
module reset_dispatch_lines
  import reset_dispatch_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int PULSE_TICKS = 4,
  parameter logic [NUM_LINES-1:0] STICKY_MASK = (64'd1 << 12) | (64'd1 << 56)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  busStrobe_t           strobe,
  input  logic [WORD_BITS-1:0] wdata,
  output logic [WORD_BITS-1:0] rdata,
  output logic [NUM_LINES-1:0] lineRst
);

  localparam int NUM_WORDS = NUM_LINES / WORD_BITS;
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int WIDX = n / WORD_BITS;
    localparam int BIDX = n % WORD_BITS;

    logic hit;
    assign hit = strobe.wrEn && (strobe.wrWord == WORD_IDX_W'(WIDX));

    if (STICKY_MASK[n]) begin : g_held
      logic heldQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    heldQ <= 1'b1;
        else if (hit) heldQ <= wdata[BIDX];
      end
      assign lineRst[n] = heldQ;
    end else begin : g_pulse
      logic [CNT_W-1:0] cntQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          cntQ <= '0;
        else if (hit && wdata[BIDX])        cntQ <= CNT_LOAD;
        else if (tickEn && cntQ != '0)      cntQ <= cntQ - 1'b1;
      end
      assign lineRst[n] = (cntQ != '0);
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strobe.rdStat && strobe.rdWord == WORD_IDX_W'(w))
        rdata = ~lineRst[w*WORD_BITS +: WORD_BITS];
    end
  end

endmodule

// File: rtl/reset_dispatch.sv
module reset_dispatch
  import reset_dispatch_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_LINES = 64,
  parameter int PULSE_TICKS = 4,
  parameter logic [NUM_LINES-1:0] STICKY_MASK = (64'd1 << 12) | (64'd1 << 56),
  parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] STAT_BASE = 12'h150
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [WORD_BITS-1:0] busWdata,
  output logic [WORD_BITS-1:0] busRdata,
  output logic [NUM_LINES-1:0] lineRst,
  output logic                 sysRstReq
);

  localparam int NUM_WORDS = NUM_LINES / WORD_BITS;

  busStrobe_t strobe;

  reset_dispatch_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
    .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
  ) ctrl_i (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strobe(strobe)
  );

  reset_dispatch_lines #(
    .NUM_LINES(NUM_LINES), .PULSE_TICKS(PULSE_TICKS), .STICKY_MASK(STICKY_MASK)
  ) lines_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .wdata(busWdata), .rdata(busRdata), .lineRst(lineRst)
  );

  assign sysRstReq = lineRst[0];

endmodule

// File: rtl/reset_dispatch_chk.sv
module reset_dispatch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tickEn,
  input logic        busValid,
  input logic        busWrite,
  input logic [11:0] busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [63:0] lineRst,
  input logic        sysRstReq
);

  logic wr0, wr1, rdCtrl;
  assign wr0 = busValid && busWrite && busAddr == 12'h100;
  assign wr1 = busValid && busWrite && busAddr == 12'h104;
  assign rdCtrl = busValid && !busWrite && (busAddr == 12'h100 || busAddr == 12'h104);

  // R3
  a_r3_status_low: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == 12'h154) |-> busRdata == ~lineRst[63:32]);

  // R4
  a_r4_write_asserts: assert property (@(posedge clk) disable iff (!rstN)
    wr0 |=> (lineRst[31:0] & $past(busWdata)) == $past(busWdata));

  // R5 / R8: without a write or a tick, no line moves
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!wr0 && !wr1 && !tickEn) |=> $stable(lineRst));

  // R8
  a_r8_held_release: assert property (@(posedge clk) disable iff (!rstN)
    (wr1 && !busWdata[24]) |=> !lineRst[56]);

  // R9
  a_r9_sys_request: assert property (@(posedge clk) disable iff (!rstN)
    (wr0 && busWdata[0]) |=> sysRstReq);

  // R10
  a_r10_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdCtrl |-> busRdata == 32'h0);

endmodule

bind reset_dispatch reset_dispatch_chk chk_i (.*);

// File: tb/reset_dispatch_tb_top.sv
module reset_dispatch_tb_top;

  localparam int P = 4;
  localparam logic [63:0] STK = (64'd1 << 12) | (64'd1 << 56);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] lineRst;
  logic        sysRstReq;

  int nTests = 0;
  int nFail = 0;
  int mCnt [64];
  logic [63:0] mHeld;

  reset_dispatch dut_i (.*);

  always #10 clk = ~clk;

  initial begin
    #4000000;
    nTests++; nFail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expLines();
    logic [63:0] v;
    for (int n = 0; n < 64; n++) v[n] = STK[n] ? mHeld[n] : (mCnt[n] != 0);
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [63:0] v = expLines();
    if (a == 12'h150) return ~v[31:0];
    if (a == 12'h154) return ~v[63:32];
    return 32'h0;
  endfunction

  task automatic modelEdge(input logic v, input logic w, input logic [11:0] a,
                           input logic [31:0] d, input logic t);
    int word = -1;
    if (v && w && a == 12'h100) word = 0;
    if (v && w && a == 12'h104) word = 1;
    for (int n = 0; n < 64; n++) begin
      logic hit = (word == n / 32);
      logic b = d[n % 32];
      if (STK[n]) begin
        if (hit) mHeld[n] = b;
      end else if (hit && b) mCnt[n] = P;
      else if (t && mCnt[n] != 0) mCnt[n]--;
    end
  endtask

  // one cycle: drive at negedge, check read, clock, check lines
  task automatic cyc(input logic v, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic t, input string tag);
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d; tickEn = t;
    #1;
    if (v && !w) check({tag, " read"}, {32'h0, busRdata}, {32'h0, expRead(a)});
    @(posedge clk);
    modelEdge(v, w, a, d, t);
    #1;
    check({tag, " lines"}, lineRst, expLines());
    check("R9 sysreq", {63'h0, sysRstReq}, {63'h0, lineRst[0]});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic t, input string tag);
    cyc(1'b1, 1'b1, a, d, t, tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
  endtask

  task automatic idle(input logic t, input string tag);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, t, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int n = 0; n < 64; n++) mCnt[n] = 0;
    mHeld = STK;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset lines", lineRst, STK);
    check("R1 sysreq", {63'h0, sysRstReq}, 64'h0);
    @(negedge clk); rstN = 1'b1;

    rd(12'h150, "R3 R2 status0 after reset");
    rd(12'h154, "R3 R2 status1 after reset");
    rd(12'h100, "R10 ctrl0 read");
    rd(12'h0F0, "R10 unmapped read");

    // R4/R5 pulse with exact tick count, tick in write cycle ignored
    wr(12'h100, 32'h0000_1020, 1'b1, "R4 start line5");
    check("R4 line5 set", {63'h0, lineRst[5]}, 64'h1);
    idle(1'b0, "R5 no tick"); idle(1'b0, "R5 no tick");
    for (int i = 0; i < P - 1; i++) idle(1'b1, "R5 counting");
    check("R5 line5 before last", {63'h0, lineRst[5]}, 64'h1);
    idle(1'b1, "R5 last tick");
    check("R5 line5 released", {63'h0, lineRst[5]}, 64'h0);

    // R6 restart mid count
    wr(12'h104, 32'h0100_0008, 1'b0, "R6 start line35");
    idle(1'b1, "R6"); idle(1'b1, "R6");
    wr(12'h104, 32'h0100_0008, 1'b1, "R6 rewrite");
    for (int i = 0; i < P - 1; i++) idle(1'b1, "R6 after rewrite");
    check("R6 line35 still held", {63'h0, lineRst[35]}, 64'h1);
    idle(1'b1, "R6 end");
    check("R6 line35 released", {63'h0, lineRst[35]}, 64'h0);

    // R7 zero to a counting line, R8 zero releases line 12
    wr(12'h100, 32'h0000_0040, 1'b0, "R7 start line6");
    wr(12'h100, 32'h0000_0000, 1'b0, "R7 R8 zero write");
    check("R7 line6 kept", {63'h0, lineRst[6]}, 64'h1);
    check("R8 line12 released", {63'h0, lineRst[12]}, 64'h0);
    check("R8 line56 untouched", {63'h0, lineRst[56]}, 64'h1);
    rd(12'h150, "R3 status0 mixed");
    wr(12'h104, 32'h0, 1'b1, "R8 release line56");
    check("R8 line56 released", {63'h0, lineRst[56]}, 64'h0);
    wr(12'h104, 32'h0100_0000, 1'b0, "R8 reassert 56");
    repeat (2 * P) idle(1'b1, "R8 held through ticks");
    check("R8 line56 held", {63'h0, lineRst[56]}, 64'h1);

    // R9 core line
    wr(12'h100, 32'h0000_1001, 1'b0, "R9 core line");
    check("R9 sysreq up", {63'h0, sysRstReq}, 64'h1);

    // R10 unmapped and status writes ignored
    wr(12'h108, 32'hFFFF_FFFF, 1'b0, "R10 unmapped write");
    wr(12'h150, 32'hFFFF_FFFF, 1'b0, "R10 status write");
    wr(12'h0FC, 32'hFFFF_FFFF, 1'b0, "R10 below base write");
    rd(12'h104, "R10 ctrl1 read");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      logic t = ($urandom_range(0, 3) == 0);
      logic [31:0] d = $urandom & $urandom & $urandom;
      logic [11:0] a;
      case ($urandom_range(0, 5))
        0: a = 12'h100; 1: a = 12'h104; 2: a = 12'h150;
        3: a = 12'h154; 4: a = 12'h10C; default: a = 12'($urandom);
      endcase
      if (k < 4)      wr(a, d, t, "R2 R4 R7 R8 R10 random write");
      else if (k < 6) rd(a, "R3 R10 random read");
      else            idle(t, "R5 R6 random idle");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule